// File: doc/BRIEF.md
# Sync-Interval Audio Multiplexer

This block lets a video output with no spare pin carry a square-wave tone. The video engine supplies horizontal and vertical sync timing and one colour bit per cycle. The block turns sync into an open-drain style pin. While sync is asserted, the pin is pulled low through an output enable. While sync is idle, the pin is released to high impedance. The colour bit normally carries pixel data. During each horizontal sync pulse it carries the current audio level instead, so picture and sound use the wire at separate times.

Pitch is set in scan lines. The rising edge of horizontal sync marks the start of a line. After a programmed number of lines, the audio level flips. Lines are counted through vertical blanking as well, so the tone has no gap at the frame rate. A period of zero silences the channel. A newly written period waits for the next flip of the tone before it is used, so no half-cycle is ever cut short.

Top module: `sync_audio_mux`

## Requirements
- R1: While rst_ni is low, sync_oe_o, color_o and audio_gate_o are all 0.
- R2: One cycle after hsync_i or vsync_i is high, sync_oe_o is 1, meaning the pin is pulled low. One cycle after both are low, sync_oe_o is 0, meaning the pin is high impedance.
- R3: One cycle after a cycle with both syncs low, color_o equals that cycle's pix_i. One cycle after a cycle with vsync_i high and hsync_i low, color_o is 0.
- R4: One cycle after a cycle with hsync_i and audio_en_i both high, audio_gate_o is 1 and color_o is the audio level. In every other case audio_gate_o is 0.
- R5: One cycle after a cycle with hsync_i high and audio_en_i low, color_o is 0.
- R6: A line starts on a rising edge of hsync_i. With an active period of N (1 to 1023), the audio level inverts on every Nth line start, so each half-wave lasts N lines.
- R7: With an active period of 0, the audio level is held at 0 and the line counter stays cleared.
- R8: period_i is captured when period_we_i is high. The captured value becomes active only at the next inversion boundary of the tone. When the channel is silent, it becomes active at the next line start. If the value loaded at a boundary is 0, the level drops to 0 there instead of inverting.
- R9: Line starts that occur while vsync_i is high are counted like any other line.
- R10: The audio level changes only on a line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync asserted, active high |
| vsync_i | input | 1 | Vertical sync asserted, active high |
| pix_i | input | 1 | Pixel colour bit from the video engine |
| audio_en_i | input | 1 | Allows audio onto the colour bit during horizontal sync |
| period_we_i | input | 1 | Write strobe for the tone period |
| period_i | input | PERIOD_W (10) | Tone half-period in lines; 0 means silent |
| sync_oe_o | output | 1 | Sync pin output enable; when 1 the pin is driven low |
| color_o | output | 1 | Colour bit: pixel, audio level or blank |
| audio_gate_o | output | 1 | High while the colour bit carries audio |

## Verification
Some properties are checked on every cycle. These are the sync pin enable following the sync inputs, pixel pass-through outside sync, the audio gate never opening outside sync, the audio level moving only on line starts, the active period changing only at a line start, and the line counter staying below the active period. Other behaviour can only be seen through the bench's line sequences. This covers the exact half-wave length in lines, the deferred period update and the drop to silence at a boundary. It also covers the wake-up from silence and continued counting through vertical blanking. The bench tracks these in a line-level reference model and observes them on the colour bit during each horizontal sync pulse.

// File: rtl/sam_pkg.sv
package sam_pkg;
  parameter int PERIOD_W_DEF = 10;

  typedef enum logic [1:0] {
    SRC_PIX   = 2'd0,
    SRC_TONE  = 2'd1,
    SRC_BLANK = 2'd2
  } color_src_e;
endpackage

// File: rtl/sam_line_detect.sv
module sam_line_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  output logic line_stb_o
);
  logic hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hs_q <= 1'b0;
    else         hs_q <= hsync_i;
  end

  assign line_stb_o = hsync_i & ~hs_q;

  assert_stb_is_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_stb_o |=> !line_stb_o);
endmodule

// File: rtl/sam_tone_div.sv
module sam_tone_div #(
  parameter int PERIOD_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                line_stb_i,
  input  logic                period_we_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tone_o
);
  localparam logic [PERIOD_W-1:0] ZERO = '0;
  localparam logic [PERIOD_W-1:0] ONE  = {{(PERIOD_W-1){1'b0}}, 1'b1};

  logic [PERIOD_W-1:0] pend_q, act_q, cnt_q;
  logic                tone_q;
  logic                silent, boundary;

  assign silent   = (act_q == ZERO);
  assign boundary = line_stb_i & ~silent & (cnt_q == act_q - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= ZERO;
    else if (period_we_i) pend_q <= period_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= ZERO;
      cnt_q  <= ZERO;
      tone_q <= 1'b0;
    end else if (line_stb_i) begin
      if (silent) begin
        act_q  <= pend_q;
        cnt_q  <= ZERO;
        tone_q <= 1'b0;
      end else if (boundary) begin
        act_q  <= pend_q;
        cnt_q  <= ZERO;
        tone_q <= (pend_q == ZERO) ? 1'b0 : ~tone_q;
      end else begin
        cnt_q  <= cnt_q + ONE;
      end
    end
  end

  assign tone_o = tone_q;

  assert_tone_on_line_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_stb_i |=> $stable(tone_q));
  assert_period_deferred_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_stb_i |=> $stable(act_q));
  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == ZERO) || (cnt_q < act_q));
  assert_silent_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == ZERO) |-> (!tone_q && cnt_q == ZERO));
endmodule

// File: rtl/sam_out_gate.sv
module sam_out_gate
  import sam_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic vsync_i,
  input  logic pix_i,
  input  logic audio_en_i,
  input  logic tone_i,
  output logic sync_oe_o,
  output logic color_o,
  output logic audio_gate_o
);
  color_src_e src;
  logic       sync_act, gate, col_d;

  assign sync_act = hsync_i | vsync_i;
  assign gate     = hsync_i & audio_en_i;

  always_comb begin
    if (gate)          src = SRC_TONE;
    else if (sync_act) src = SRC_BLANK;
    else               src = SRC_PIX;
  end

  always_comb begin
    unique case (src)
      SRC_TONE: col_d = tone_i;
      SRC_PIX:  col_d = pix_i;
      default:  col_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_oe_o    <= 1'b0;
      color_o      <= 1'b0;
      audio_gate_o <= 1'b0;
    end else begin
      sync_oe_o    <= sync_act;
      color_o      <= col_d;
      audio_gate_o <= gate;
    end
  end

  assert_sync_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i || vsync_i) |=> sync_oe_o);
  assert_sync_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsync_i && !vsync_i) |=> !sync_oe_o);
  assert_pix_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsync_i && !vsync_i) |=> (color_o == $past(pix_i)));
  assert_gate_in_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    audio_gate_o |-> sync_oe_o);
  assert_disabled_blank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i && !audio_en_i) |=> (!color_o && !audio_gate_o));
endmodule

// File: rtl/sync_audio_mux.sv
module sync_audio_mux #(
  parameter int PERIOD_W = sam_pkg::PERIOD_W_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hsync_i,
  input  logic                vsync_i,
  input  logic                pix_i,
  input  logic                audio_en_i,
  input  logic                period_we_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                sync_oe_o,
  output logic                color_o,
  output logic                audio_gate_o
);
  logic line_stb, tone;

  sam_line_detect u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hsync_i    (hsync_i),
    .line_stb_o (line_stb)
  );

  sam_tone_div #(.PERIOD_W(PERIOD_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_stb_i  (line_stb),
    .period_we_i (period_we_i),
    .period_i    (period_i),
    .tone_o      (tone)
  );

  sam_out_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hsync_i      (hsync_i),
    .vsync_i      (vsync_i),
    .pix_i        (pix_i),
    .audio_en_i   (audio_en_i),
    .tone_i       (tone),
    .sync_oe_o    (sync_oe_o),
    .color_o      (color_o),
    .audio_gate_o (audio_gate_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni -> (!sync_oe_o && !color_o && !audio_gate_o)));
endmodule

// File: tb/sync_audio_mux_tb_top.sv
module sync_audio_mux_tb_top;
  localparam int PW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 0, vs = 0, pix = 0, en = 0, pwe = 0;
  logic [PW-1:0] pd = '0;
  logic oe, col, gate;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string cur_tag = "R6";

  // reference model state
  logic [PW-1:0] m_pend = '0, m_act = '0, m_cnt = '0;
  logic m_tone = 0, m_prev_h = 0;
  logic e_oe, e_col, e_gate, have_exp = 0;
  logic [PW-1:0] wr_val = '0;
  bit wr_req = 0;

  always #2 clk = ~clk;

  sync_audio_mux #(.PERIOD_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs), .pix_i(pix),
    .audio_en_i(en), .period_we_i(pwe), .period_i(pd),
    .sync_oe_o(oe), .color_o(col), .audio_gate_o(gate)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_color(input logic h, input logic v, input logic p,
                                     input logic e, input logic t);
    if (h && e) return t;
    if (h || v) return 1'b0;
    return p;
  endfunction

  task automatic compare();
    chk("R2", oe, e_oe);
    chk(e_gate ? "R4" : "R4/R5 gate", gate, e_gate);
    if (e_gate)      chk(cur_tag, col, e_col);
    else if (e_oe)   chk(hs ? "R5" : "R3 vblank", col, e_col);
    else             chk("R3", col, e_col);
  endtask

  task automatic step(input logic h, input logic v, input logic e);
    logic line;
    @(negedge clk);
    if (have_exp) compare();
    hs = h; vs = v; en = e; pix = 1'($urandom);
    pwe = wr_req; pd = wr_val; wr_req = 0;
    line   = h && !m_prev_h;
    e_oe   = h || v;
    e_gate = h && e;
    e_col  = exp_color(h, v, pix, e, m_tone);
    if (line) begin
      if (m_act == 0) begin
        m_act = m_pend; m_cnt = 0; m_tone = 0;
      end else if (m_cnt == m_act - 1) begin
        m_cnt = 0; m_tone = (m_pend == 0) ? 1'b0 : ~m_tone; m_act = m_pend;
      end else m_cnt = m_cnt + 1;
    end
    if (pwe) m_pend = pd;
    m_prev_h = h;
    have_exp = 1;
  endtask

  task automatic line_run(input int hl, input int ll, input logic v, input logic e);
    for (int i = 0; i < hl; i++) step(1'b1, v, e);
    for (int i = 0; i < ll; i++) step(1'b0, v, e);
  endtask

  task automatic write_period(input int val);
    wr_req = 1; wr_val = PW'(val);
  endtask

  initial begin
    void'($urandom(32'h5A3C_0011));
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    hs = 1; vs = 1; pix = 1; en = 1;
    @(negedge clk);
    chk("R1 oe", oe, 1'b0); chk("R1 col", col, 1'b0); chk("R1 gate", gate, 1'b0);
    hs = 0; vs = 0; pix = 0; en = 0;
    @(negedge clk);
    rst_n = 1;

    // R7: silent at period 0
    cur_tag = "R7";
    for (int i = 0; i < 6; i++) line_run(2, 4, 1'b0, 1'b1);

    // R8: wake from silence, period 3
    cur_tag = "R8";
    write_period(3);
    for (int i = 0; i < 8; i++) line_run(2, 4, 1'b0, 1'b1);

    // R6: period 1 toggles every line
    cur_tag = "R6";
    write_period(1);
    for (int i = 0; i < 10; i++) line_run(1, 3, 1'b0, 1'b1);

    // R8: mid-cycle write deferred to boundary
    cur_tag = "R8";
    write_period(4);
    line_run(2, 3, 1'b0, 1'b1);
    write_period(2);
    for (int i = 0; i < 12; i++) line_run(2, 3, 1'b0, 1'b1);

    // R9: counting through vertical blanking
    cur_tag = "R9";
    for (int i = 0; i < 10; i++) line_run(2, 3, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) line_run(2, 3, 1'b0, 1'b1);

    // R5: disabled audio blanks colour in hsync
    for (int i = 0; i < 4; i++) line_run(3, 3, 1'b0, 1'b0);

    // R7 + R8: write 0 drops tone at boundary
    cur_tag = "R7";
    write_period(0);
    for (int i = 0; i < 6; i++) line_run(2, 3, 1'b0, 1'b1);

    // R10 + R6: random lines with random writes
    cur_tag = "R10";
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 19);
      if (r == 0) write_period(0);
      else if (r == 1) write_period(1);
      else if (r == 2) write_period($urandom_range(1, 20));
      else if (r == 3 && i % 50 == 0) write_period(1023);
      line_run($urandom_range(1, 4), $urandom_range(1, 8),
               ($urandom_range(0, 7) == 0), ($urandom_range(0, 9) != 0));
    end
    step(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    compare();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule